// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Front-End

This block is the bus-facing half of a 512-byte serial memory. It oversamples the two-wire clock and data lines with a fast system clock and filters both lines. It finds START, repeated START and STOP conditions, shifts bytes most significant bit first, and answers its 7-bit device address. It drives the data line only by pulling it low through an output enable. The storage array, the page latch and the erase/write timer sit outside the block. The block gives them a 9-bit address, write strobes for a page latch, read strobes, and a commit pulse at the STOP that closes a valid write. The timer answers back through a busy input.

The device address byte holds a fixed code 1010, then two strap pins, then a software half-select bit, then the read/write bit. The half-select bit becomes bit 8 of the memory pointer, and the word-address byte sets bits 7..0. A write stores up to a page of eight bytes. The three low pointer bits wrap inside the page while bits 8..3 stay fixed. Reads continue for as long as the master acknowledges. During a read the low eight pointer bits wrap inside the selected 256-byte half. A write-lock input protects only the upper half. With the lock set, the address bytes are still acknowledged but data bytes aimed at the upper half are refused.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, sda_oe is 0 and none of mem_wr, mem_rd, mem_commit is asserted.
- R2: The device address byte is acknowledged only when its bits 7..4 are 1010, bit 3 equals strap_hi and bit 2 equals strap_lo. Bit 1 selects the memory half and bit 0 set to 1 means read. Any other byte gets no acknowledge, and the block stays silent until the next START.
- R3: While mem_busy is 1, the device address byte is not acknowledged.
- R4: A write is a device byte with bit 0 = 0, then a word-address byte, then data bytes, all acknowledged. Each data byte gives one mem_wr pulse, with mem_addr = {half, pointer} and mem_wdata set to the byte. One mem_commit pulse follows the STOP if at least one byte was accepted.
- R5: In a multi-byte write, only pointer bits 2..0 advance after each byte, wrapping within the 8-byte page.
- R6: If more than eight data bytes are sent, the ninth is not acknowledged, and the STOP that follows gives no mem_commit.
- R7: With wr_lock = 1, data bytes for the upper half (pointer bit 8 = 1) are not acknowledged and give no mem_wr, while the device and word-address bytes are still acknowledged. Writes to the lower half are unaffected.
- R8: A read with no word address (current-address read) returns the byte at {half bit of the device byte, pointer bits 7..0 left by the previous access}.
- R9: A random read, made of a word-address write followed by a repeated START and a read device byte, returns the byte at {half, word address}.
- R10: During a read, a master acknowledge fetches the next byte. Pointer bits 7..0 wrap from 0xFF to 0x00 and bit 8 does not change. A master no-acknowledge ends the read with SDA released and no further fetch, so n bytes read give exactly n mem_rd pulses.
- R11: SCL or SDA pulses shorter than FILT_LEN system clocks have no effect. SDA changes only while the filtered SCL is low.
- R12: A START seen in the middle of a byte restarts device-address reception, and SDA is released after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_hi | input | 1 | Board strap compared with device-byte bit 3 |
| strap_lo | input | 1 | Board strap compared with device-byte bit 2 |
| wr_lock | input | 1 | Protects the upper 256-byte half from writes |
| mem_busy | input | 1 | Erase/write cycle in progress |
| mem_addr | output | 9 | Memory pointer {half, word} |
| mem_wdata | output | 8 | Data byte for the page latch |
| mem_wr | output | 1 | One-cycle page-latch write strobe |
| mem_rd | output | 1 | One-cycle fetch strobe; mem_rdata is taken in the same cycle |
| mem_commit | output | 1 | One-cycle pulse starting the program cycle after STOP |
| mem_rdata | input | 8 | Byte at mem_addr, valid in the same cycle |

## Verification
Glitch rejection and START/STOP detection share one filtered view of the lines, so a short SDA dip while SCL is high and a real START are decided in the same cycle by the same filter counters. The bench provokes this by writing a byte sequence where every SCL low phase carries a 2-clock high spike and every high data bit carries a 2-clock low dip on SDA. It judges the result by whether all bytes are acknowledged, exactly one commit follows, and a clean read returns the written values. The second collision is the page-pointer advance against the 8-byte page boundary. A write that starts at word 0x1D must land at 0x1D, 0x1E, 0x1F and then 0x18..0x1C, and this is checked by reading the whole page back.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int          FILT_LEN  = 3,
  parameter int          PAGE_BITS = 3,
  parameter logic [3:0]  DEV_CODE  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_hi,
  input  logic       strap_lo,
  input  logic       wr_lock,
  input  logic       mem_busy,
  output logic [8:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_wr,
  output logic       mem_rd,
  output logic       mem_commit,
  input  logic [7:0] mem_rdata
);

  localparam int FCW  = $clog2(FILT_LEN + 1);
  localparam int PAGE = 1 << PAGE_BITS;

  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_WADDR, PH_WDATA, PH_RDATA} phase_t;

  logic [1:0]     raw, s1, s2, flt, flt_q;
  logic [FCW-1:0] fc [2];

  assign raw = {sda_i, scl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; flt_q <= 2'b11;
      for (int i = 0; i < 2; i++) fc[i] <= '0;
    end else begin
      s1    <= raw;
      s2    <= s1;
      flt_q <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fc[i] <= '0;
        else if (fc[i] == FCW'(FILT_LEN - 1)) begin
          flt[i] <= s2[i];
          fc[i]  <= '0;
        end else fc[i] <= fc[i] + 1'b1;
      end
    end
  end

  logic scl_f, scl_fq, sda_f, sda_fq;
  assign scl_f  = flt[0];
  assign scl_fq = flt_q[0];
  assign sda_f  = flt[1];
  assign sda_fq = flt_q[1];

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_f & scl_fq & sda_fq & ~sda_f;
  assign stop_det  = scl_f & scl_fq & ~sda_fq & sda_f;
  assign scl_rise  = scl_f & ~scl_fq;
  assign scl_fall  = ~scl_f & scl_fq;

  phase_t             phase;
  logic [3:0]         bitcnt;
  logic [7:0]         shreg, tx;
  logic [8:0]         ptr;
  logic               rd_mode, mack, abort;
  logic [PAGE_BITS:0] wcnt;

  logic dev_match;
  assign dev_match = (shreg[7:4] == DEV_CODE) && (shreg[3] == strap_hi) && (shreg[2] == strap_lo);
  assign mem_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      rd_mode <= 1'b0; mack <= 1'b0; abort <= 1'b0; wcnt <= '0;
      sda_oe <= 1'b0; mem_wr <= 1'b0; mem_rd <= 1'b0; mem_commit <= 1'b0; mem_wdata <= '0;
    end else begin
      mem_wr     <= 1'b0;
      mem_rd     <= 1'b0;
      mem_commit <= 1'b0;
      if (mem_wr) ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
      if (mem_rd) begin
        tx       <= mem_rdata;
        sda_oe   <= ~mem_rdata[7];
        ptr[7:0] <= ptr[7:0] + 8'd1;
      end
      if (start_det) begin
        phase <= PH_DEV; bitcnt <= '0; sda_oe <= 1'b0; wcnt <= '0; abort <= 1'b0;
      end else if (stop_det) begin
        if (wcnt != '0 && !abort) mem_commit <= 1'b1;
        phase <= PH_IDLE; sda_oe <= 1'b0; wcnt <= '0; abort <= 1'b0;
      end else if (scl_rise && phase != PH_IDLE) begin
        if (phase == PH_RDATA) begin
          if (bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
          else if (bitcnt == 4'd8) begin
            mack   <= ~sda_f;
            bitcnt <= 4'd9;
          end
        end else if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_f};
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (scl_fall && phase != PH_IDLE) begin
        if (phase == PH_RDATA) begin
          if (bitcnt > 4'd0 && bitcnt < 4'd8) begin
            tx     <= {tx[6:0], 1'b1};
            sda_oe <= ~tx[6];
          end else if (bitcnt == 4'd8) sda_oe <= 1'b0;
          else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (mack) mem_rd <= 1'b1;
            else phase <= PH_IDLE;
          end
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          case (phase)
            PH_DEV: begin
              if (dev_match && !mem_busy) begin
                sda_oe  <= 1'b1;
                ptr[8]  <= shreg[1];
                rd_mode <= shreg[0];
              end else phase <= PH_IDLE;
            end
            PH_WADDR: begin
              sda_oe   <= 1'b1;
              ptr[7:0] <= shreg;
              wcnt     <= '0;
            end
            PH_WDATA: begin
              if (wcnt == (PAGE_BITS+1)'(PAGE)) begin
                abort <= 1'b1;
                phase <= PH_IDLE;
              end else if (wr_lock && ptr[8]) phase <= PH_IDLE;
              else begin
                sda_oe    <= 1'b1;
                mem_wr    <= 1'b1;
                mem_wdata <= shreg;
                wcnt      <= wcnt + 1'b1;
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end else if (bitcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          case (phase)
            PH_DEV: begin
              if (rd_mode) begin
                phase  <= PH_RDATA;
                mem_rd <= 1'b1;
              end else phase <= PH_WADDR;
            end
            PH_WADDR: phase <= PH_WDATA;
            default:  phase <= phase;
          endcase
        end
      end
    end
  end

  AST_LOCKED_HALF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !($past(wr_lock) && mem_addr[8])) else $error("locked half written"); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd, mem_commit})) else $error("strobes overlap"); // R4
  AST_COMMIT_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit |-> $past(stop_det)) else $error("commit without stop"); // R4
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && scl_fq) |-> $stable(sda_oe)) else $error("sda moved while scl high"); // R11
  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe) else $error("sda held after stop"); // R12

endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wr_lock = 1'b0, mem_busy = 1'b0, drop = 1'b0;
  logic sda_oe, mem_wr, mem_rd, mem_commit;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_hi(1'b1), .strap_lo(1'b0), .wr_lock(wr_lock), .mem_busy(mem_busy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_commit(mem_commit), .mem_rdata(mem_rdata));

  function automatic logic [7:0] finit(int a);
    return 8'((a * 29 + 7) ^ (a >> 4));
  endfunction

  function automatic logic [7:0] devb(bit h, bit rw);
    return {4'b1010, 1'b1, 1'b0, h, rw};
  endfunction

  logic [7:0] bmem [512];
  logic [7:0] stg  [512];
  logic       stv  [512];
  logic [7:0] expm [512];
  int nwr = 0, nrd = 0, ncommit = 0;
  int checks = 0, errs = 0;

  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 512; a++) begin bmem[a] <= finit(a); stv[a] <= 1'b0; stg[a] <= 8'h00; end
    end else begin
      if (drop) for (int a = 0; a < 512; a++) stv[a] <= 1'b0;
      if (mem_wr) begin stg[mem_addr] <= mem_wdata; stv[mem_addr] <= 1'b1; nwr <= nwr + 1; end
      if (mem_rd) nrd <= nrd + 1;
      if (mem_commit) begin
        for (int a = 0; a < 512; a++) if (stv[a]) begin bmem[a] <= stg[a]; stv[a] <= 1'b0; end
        ncommit <= ncommit + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic sbyte(input logic [7:0] b, output bit ack, input bit gl = 1'b0);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (gl) begin wq(3); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q - 5); end
      else wq();
      scl_m = 1'b1;
      if (gl && b[i]) begin wq(4); sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(2 * Q - 6); end
      else wq(2 * Q);
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = !sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rbyte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m = !mack; wq(); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic wr_seq(input bit h, input logic [7:0] w, input int n, input logic [7:0] seed,
                        input bit gl, output bit a_dev, output bit a_wa, output int nacked);
    bit a;
    nacked = 0;
    bstart();
    sbyte(devb(h, 1'b0), a_dev, gl);
    sbyte(w, a_wa, gl);
    for (int k = 0; k < n; k++) begin
      sbyte(8'(seed + k * 17), a, gl);
      if (a) nacked++;
    end
    bstop();
    wq(4);
  endtask

  task automatic model_write(input bit h, input logic [7:0] w, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) expm[{h, w[7:3], 3'(w[2:0] + k)}] = 8'(seed + k * 17);
  endtask

  task automatic rd_seq(input bit h, input logic [7:0] w, input int n, input string tag);
    bit a;
    logic [7:0] b;
    bstart();
    sbyte(devb(h, 1'b0), a); chk(a, tag, a, 1);
    sbyte(w, a);             chk(a, tag, a, 1);
    bstart();
    sbyte(devb(h, 1'b1), a); chk(a, tag, a, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(b, k != n - 1);
      chk(b == expm[{h, 8'(w + k)}], tag, b, expm[{h, 8'(w + k)}]);
    end
    bstop();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    bit a, ad, aw;
    int na, c0, w0, r0;
    logic [7:0] b, db;
    for (int x = 0; x < 512; x++) expm[x] = finit(x);
    wq(5);
    chk(!sda_oe && !mem_wr && !mem_rd && !mem_commit, "R1 in reset", {sda_oe, mem_wr, mem_rd, mem_commit}, 0);
    rst_n = 1'b1;
    wq(5);
    chk(!sda_oe && !mem_wr && !mem_rd && !mem_commit, "R1 after reset", {sda_oe, mem_wr, mem_rd, mem_commit}, 0);

    // R2: sweep all 128 address patterns, A0 and R/W tied together
    for (int d = 0; d < 128; d++) begin
      db = {7'(d), 1'(d)};
      bstart();
      sbyte(db, a);
      chk(a == (db[7:2] == 6'b101010), "R2 address match", a, db[7:2] == 6'b101010);
      if (a && db[0]) begin
        rbyte(b, 1'b0);
        chk(b == expm[9'h100], "R8 current read after reset", b, expm[9'h100]);
      end
      bstop();
    end

    // R3: busy refuses address
    mem_busy = 1'b1;
    bstart(); sbyte(devb(0, 0), a); bstop();
    chk(!a, "R3 busy nack", a, 0);
    mem_busy = 1'b0;
    bstart(); sbyte(devb(0, 0), a); bstop();
    chk(a, "R3 idle ack", a, 1);

    // R4: single byte write lower half
    c0 = ncommit; w0 = nwr;
    wr_seq(0, 8'h33, 1, 8'h5A, 0, ad, aw, na);
    chk(ad && aw && na == 1, "R4 acks", {ad, aw, 8'(na)}, 'h301);
    chk(nwr == w0 + 1 && ncommit == c0 + 1, "R4 strobes", {nwr - w0, ncommit - c0}, 'h100000001);
    model_write(0, 8'h33, 1, 8'h5A);
    rd_seq(0, 8'h33, 1, "R4 readback");

    // R5: page write with wrap inside the page
    c0 = ncommit;
    wr_seq(1, 8'h1D, 8, 8'hC1, 0, ad, aw, na);
    chk(na == 8 && ncommit == c0 + 1, "R5 page acks", na, 8);
    model_write(1, 8'h1D, 8, 8'hC1);
    rd_seq(1, 8'h18, 8, "R5 page readback");

    // R6: ninth byte refused, whole write dropped
    c0 = ncommit;
    wr_seq(0, 8'h40, 9, 8'h23, 0, ad, aw, na);
    chk(na == 8, "R6 ninth nack", na, 8);
    chk(ncommit == c0, "R6 no commit", ncommit - c0, 0);
    drop = 1'b1; wq(1); drop = 1'b0;
    rd_seq(0, 8'h40, 8, "R6 unchanged");

    // R7: write lock
    wr_lock = 1'b1;
    w0 = nwr; c0 = ncommit;
    wr_seq(1, 8'h80, 2, 8'h99, 0, ad, aw, na);
    chk(ad && aw, "R7 address bytes acked", {ad, aw}, 3);
    chk(na == 0 && nwr == w0 && ncommit == c0, "R7 upper refused", na, 0);
    rd_seq(1, 8'h80, 2, "R7 upper unchanged");
    wr_seq(0, 8'h80, 2, 8'h99, 0, ad, aw, na);
    chk(na == 2 && ncommit == c0 + 1, "R7 lower allowed", na, 2);
    model_write(0, 8'h80, 2, 8'h99);
    rd_seq(0, 8'h80, 2, "R7 lower readback");
    wr_lock = 1'b0;

    // R9 R10: random read with wrap at top of upper half
    r0 = nrd;
    rd_seq(1, 8'hFE, 4, "R10 wrap read");
    chk(nrd == r0 + 4, "R10 fetch count", nrd - r0, 4);
    chk(!sda_oe, "R10 released", sda_oe, 0);
    rd_seq(0, 8'h7F, 2, "R9 random read");

    // R8: current-address read continues from previous pointer
    rd_seq(1, 8'hFE, 4, "R10 wrap read again");
    bstart(); sbyte(devb(1, 1), a); rbyte(b, 1'b0); bstop();
    chk(a && b == expm[9'h102], "R8 current read", b, expm[9'h102]);

    // R11: glitches on both lines during a write
    c0 = ncommit;
    wr_seq(0, 8'h10, 3, 8'h77, 1, ad, aw, na);
    chk(ad && aw && na == 3 && ncommit == c0 + 1, "R11 glitch write", na, 3);
    model_write(0, 8'h10, 3, 8'h77);
    rd_seq(0, 8'h10, 3, "R11 readback");

    // R12: START and STOP in mid-byte
    c0 = ncommit;
    bstart();
    for (int i = 0; i < 4; i++) begin sda_m = 1'(i); wq(); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(); end
    wr_seq(0, 8'h60, 1, 8'h3C, 0, ad, aw, na);
    chk(ad && aw && na == 1 && ncommit == c0 + 1, "R12 restart mid-byte", na, 1);
    model_write(0, 8'h60, 1, 8'h3C);
    bstart();
    for (int i = 0; i < 3; i++) begin sda_m = 1'(i); wq(); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(); end
    bstop();
    chk(!sda_oe && ncommit == c0 + 1, "R12 stop mid-byte", ncommit - c0, 1);
    rd_seq(0, 8'h60, 1, "R12 readback");

    summary();
    $finish;
  end
endmodule